// File: doc/BRIEF.md
# Per-Task Miss-Rate Monitor and Partition Rescaler

This block sits beside a partitioned, configurable instruction cache in a multitasking system where only one task runs at a time and the scheduler rotates tasks on fixed time slices. For the running task it counts cache accesses and misses over the current slice. When a context switch ends the slice, it checks whether the measured miss rate of the outgoing task went above that task's allowed bound. If it did, the task moves one entry up a per-task ladder of cache configurations, so that it gets a larger partition the next time it runs. Each ladder entry holds a way-select vector, a set-index mask and a set base.

The bound for each task is its miss rate with the whole cache to itself, loaded by software in hundredths of a percent (basis points), plus a fixed threshold parameter with a default of 10 basis points. The comparison needs no divider: misses times 10000 is compared against accesses times the bound. When a task grows into ways that another task is currently using, that other task is pushed one step up as well, because it now shares more of its ways. When any task exits, all grown partitions fall back to their starting entries to recover the power saving. Software loads the ladders and baselines. The block drives registered configuration outputs for the running task and a one-cycle update strobe.

Top module: `partition_rescaler`

## Requirements
- R1: While reset is high, and on the first clock edge that samples it, `way_sel`, `set_mask`, `set_base` and `cfg_upd` go to zero, every task's step goes to 0 and the running task becomes task 0.
- R2: Access and miss counts restart from zero at every switch, so each slice is judged only on the strobes seen between two switches.
- R3: Both counters stop at all ones (255 when `CNT_W`=8) instead of wrapping. The saturated values are the ones that get judged.
- R4: A slice is over its bound when misses×10000 > accesses×(baseline_bp + `THRESH_BP`), using strict greater-than. When the two sides are equal, or when the slice saw no accesses, the task is not rescaled.
- R5: A slice that is over its bound moves the outgoing task's step up by exactly one.
- R6: A step never goes past `N_STEPS`-1. A task already at that entry is not changed, and no update strobe is raised for it.
- R7: When a task grows, every other task whose current ways intersect the ways just gained (the new way vector AND NOT the old one) also moves up one step, unless it is already at the last entry. The same decision that grows the task also grows these other tasks.
- R8: A pulse on `exit_stb` returns every task's step to 0 on the next edge. If the pulse falls in the cycle after a switch, the cycle in which that slice is judged, the return to 0 wins and the slice causes no rescale.
- R9: `cfg_upd` is high for one cycle, three cycles after the switch cycle of a slice that causes a rescale. After an exit pulse it is high two cycles later, and only if some task other than `exit_task` had a nonzero step. It is never high at any other time.
- R10: Outputs show the ladder entry of the running task at its current step. The new task's entry appears within two cycles after the switch cycle, and a rescaled entry appears in the same cycle as `cfg_upd`.
- R11: A ladder write with `lad_we` stores `lad_way`, `lad_mask` and `lad_base` as one entry, addressed by `lad_task` and `lad_step`. A baseline write with `bnd_we` stores `bnd_bp` for `bnd_task`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_stb | input | 1 | One cache access this cycle |
| miss_stb | input | 1 | One cache miss this cycle |
| sw_stb | input | 1 | Context switch: ends the slice of the running task |
| sw_task | input | TID_W | Task that runs after the switch |
| exit_stb | input | 1 | A task has completed |
| exit_task | input | TID_W | Id of the completed task |
| lad_we | input | 1 | Ladder entry write enable |
| lad_task | input | TID_W | Ladder write: task |
| lad_step | input | STEP_W | Ladder write: step index |
| lad_way | input | WAY_W | Ladder write: way-select vector |
| lad_mask | input | MASK_W | Ladder write: set-index mask |
| lad_base | input | BASE_W | Ladder write: set base |
| bnd_we | input | 1 | Baseline write enable |
| bnd_task | input | TID_W | Baseline write: task |
| bnd_bp | input | BP_W | Isolated baseline miss rate in basis points |
| way_sel | output | WAY_W | Way-select vector for the running task |
| set_mask | output | MASK_W | Set-index mask for the running task |
| set_base | output | BASE_W | Set base for the running task |
| cfg_upd | output | 1 | One-cycle pulse when a rescale or reversion takes effect |

## Verification
The bench builds the block with four tasks, a four-entry ladder and 8-bit slice counters, and keeps the 10 basis-point threshold. With these values a few hundred strobes saturate the counters, so a wrap would change a verdict (R3). A handful of over-bound slices drives a task to its last entry (R6). Each task's way vector grows by one rotating bit per step, so a task that grows runs into its neighbour's ways after one step, and the forced growth of the other task (R7) is reached within the directed part. The random part then mixes switches, exits and exits placed in the judging cycle.

// File: rtl/pr_pkg.sv
package pr_pkg;

  // 100 percent expressed in basis points
  localparam int unsigned SCALE_BP = 10000;

  // Kind of decision taken in a cycle by the step controller
  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,
    DEC_GROW   = 2'd1,
    DEC_REVERT = 2'd2
  } dec_kind_e;

endpackage

// File: rtl/pr_slice_counter.sv
module pr_slice_counter #(
  parameter int CNT_W = 16,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_stb,
  input  logic             miss_stb,
  input  logic             sw_stb,
  input  logic [TID_W-1:0] sw_task,
  output logic [TID_W-1:0] run_task,
  output logic             snap_v,
  output logic [TID_W-1:0] snap_task,
  output logic [CNT_W-1:0] snap_acc,
  output logic [CNT_W-1:0] snap_miss
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] acc_q, miss_q;
  logic [CNT_W-1:0] acc_n, miss_n;

  // saturating increments
  always_comb begin
    acc_n  = (acc_stb  && acc_q  != CNT_TOP) ? acc_q  + CNT_W'(1) : acc_q;
    miss_n = (miss_stb && miss_q != CNT_TOP) ? miss_q + CNT_W'(1) : miss_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      miss_q    <= '0;
      run_task  <= '0;
      snap_v    <= 1'b0;
      snap_task <= '0;
      snap_acc  <= '0;
      snap_miss <= '0;
    end else begin
      snap_v <= sw_stb;
      if (sw_stb) begin
        snap_acc  <= acc_n;
        snap_miss <= miss_n;
        snap_task <= run_task;
        run_task  <= sw_task;
        acc_q     <= '0;
        miss_q    <= '0;
      end else begin
        acc_q  <= acc_n;
        miss_q <= miss_n;
      end
    end
  end

  AST_SLICE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    sw_stb |=> (acc_q == '0 && miss_q == '0)); // R2

  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (acc_q == CNT_TOP && !sw_stb) |=> acc_q == CNT_TOP); // R3

  AST_MISS_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (miss_q == CNT_TOP && !sw_stb) |=> miss_q == CNT_TOP); // R3

endmodule

// File: rtl/pr_rate_judge.sv
module pr_rate_judge
  import pr_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BP_W      = 14,
  parameter int THRESH_BP = 10
) (
  input  logic [CNT_W-1:0] acc,
  input  logic [CNT_W-1:0] miss,
  input  logic [BP_W-1:0]  base_bp,
  output logic             over
);

  localparam int PROD_W = CNT_W + BP_W + 1;

  logic [BP_W:0]     bound;
  logic [PROD_W-1:0] lhs, rhs;

  // miss/acc > bound/10000  <=>  miss*10000 > acc*bound
  always_comb begin
    bound = {1'b0, base_bp} + (BP_W+1)'(THRESH_BP);
    lhs   = PROD_W'(miss) * PROD_W'(SCALE_BP);
    rhs   = PROD_W'(acc)  * PROD_W'(bound);
    over  = lhs > rhs;
  end

endmodule

// File: rtl/pr_ladder_store.sv
module pr_ladder_store #(
  parameter int N_TASKS = 4,
  parameter int N_STEPS = 8,
  parameter int WAY_W   = 4,
  parameter int ENT_W   = 20,
  parameter int BP_W    = 14
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                lad_we,
  input  logic [$clog2(N_TASKS)-1:0]          lad_task,
  input  logic [$clog2(N_STEPS)-1:0]          lad_step,
  input  logic [ENT_W-1:0]                    lad_data,
  input  logic                                bnd_we,
  input  logic [$clog2(N_TASKS)-1:0]          bnd_task,
  input  logic [BP_W-1:0]                     bnd_bp,
  input  logic [N_TASKS-1:0][$clog2(N_STEPS)-1:0] step_vec,
  input  logic [$clog2(N_TASKS)-1:0]          probe_task,
  output logic [N_TASKS-1:0][ENT_W-1:0]       cur_ent,
  output logic [N_TASKS-1:0][WAY_W-1:0]       cur_way,
  output logic [WAY_W-1:0]                    nxt_way,
  output logic [BP_W-1:0]                     probe_bp
);

  localparam int TID_W  = $clog2(N_TASKS);
  localparam int STEP_W = $clog2(N_STEPS);
  localparam int DEPTH  = N_TASKS * N_STEPS;
  localparam int ADDR_W = $clog2(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [BP_W-1:0]  base_q [N_TASKS];

  function automatic logic [ADDR_W-1:0] addr_of(input logic [TID_W-1:0] t,
                                                input logic [STEP_W-1:0] s);
    return ADDR_W'(t) * ADDR_W'(N_STEPS) + ADDR_W'(s);
  endfunction

  // ladder memory: plain write port, no reset
  always_ff @(posedge clk) begin
    if (lad_we)
      mem[addr_of(lad_task, lad_step)] <= lad_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < N_TASKS; t++) base_q[t] <= '0;
    end else if (bnd_we) begin
      base_q[bnd_task] <= bnd_bp;
    end
  end

  for (genvar t = 0; t < N_TASKS; t++) begin : g_rd
    assign cur_ent[t] = mem[addr_of(TID_W'(t), step_vec[t])];
    assign cur_way[t] = cur_ent[t][ENT_W-1 -: WAY_W];
  end

  logic [ENT_W-1:0] nxt_ent;
  assign nxt_ent  = mem[addr_of(probe_task, step_vec[probe_task] + STEP_W'(1))];
  assign nxt_way  = nxt_ent[ENT_W-1 -: WAY_W];
  assign probe_bp = base_q[probe_task];

endmodule

// File: rtl/pr_step_ctrl.sv
module pr_step_ctrl
  import pr_pkg::*;
#(
  parameter int N_TASKS = 4,
  parameter int N_STEPS = 8,
  parameter int WAY_W   = 4
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    eval_v,
  input  logic [$clog2(N_TASKS)-1:0]              eval_task,
  input  logic                                    over,
  input  logic [N_TASKS-1:0][WAY_W-1:0]           cur_way,
  input  logic [WAY_W-1:0]                        nxt_way,
  input  logic                                    exit_stb,
  input  logic [$clog2(N_TASKS)-1:0]              exit_task,
  output logic [N_TASKS-1:0][$clog2(N_STEPS)-1:0] step_vec,
  output dec_kind_e                               dec_q
);

  localparam int TID_W  = $clog2(N_TASKS);
  localparam int STEP_W = $clog2(N_STEPS);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

  logic               grow;
  logic [WAY_W-1:0]   gained;
  logic [N_TASKS-1:0] bump;
  logic [N_TASKS-1:0] busy_other;

  assign grow   = eval_v && over && (step_vec[eval_task] != LAST);
  assign gained = nxt_way & ~cur_way[eval_task];

  for (genvar j = 0; j < N_TASKS; j++) begin : g_task
    assign bump[j] = grow && (step_vec[j] != LAST) &&
                     ((TID_W'(j) == eval_task) || (|(gained & cur_way[j])));
    assign busy_other[j] = (TID_W'(j) != exit_task) && (step_vec[j] != '0);

    always_ff @(posedge clk) begin
      if (rst)           step_vec[j] <= '0;
      else if (exit_stb) step_vec[j] <= '0;
      else if (bump[j])  step_vec[j] <= step_vec[j] + STEP_W'(1);
    end

    AST_STEP_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
      (step_vec[j] == LAST && !exit_stb) |=> step_vec[j] == LAST); // R6

    AST_STEP_REVERT: assert property (@(posedge clk) disable iff (rst)
      exit_stb |=> step_vec[j] == '0); // R8

    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
      !exit_stb |=> (32'(step_vec[j]) == 32'($past(step_vec[j])) ||
                     32'(step_vec[j]) == 32'($past(step_vec[j])) + 1)); // R5
  end

  always_ff @(posedge clk) begin
    if (rst)           dec_q <= DEC_IDLE;
    else if (exit_stb) dec_q <= (|busy_other) ? DEC_REVERT : DEC_IDLE;
    else               dec_q <= grow ? DEC_GROW : DEC_IDLE;
  end

endmodule

// File: rtl/partition_rescaler.sv
module partition_rescaler
  import pr_pkg::*;
#(
  parameter int N_TASKS   = 4,
  parameter int N_STEPS   = 8,
  parameter int WAY_W     = 4,
  parameter int MASK_W    = 8,
  parameter int BASE_W    = 8,
  parameter int CNT_W     = 16,
  parameter int BP_W      = 14,
  parameter int THRESH_BP = 10,
  localparam int TID_W    = $clog2(N_TASKS),
  localparam int STEP_W   = $clog2(N_STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_stb,
  input  logic              miss_stb,
  input  logic              sw_stb,
  input  logic [TID_W-1:0]  sw_task,
  input  logic              exit_stb,
  input  logic [TID_W-1:0]  exit_task,
  input  logic              lad_we,
  input  logic [TID_W-1:0]  lad_task,
  input  logic [STEP_W-1:0] lad_step,
  input  logic [WAY_W-1:0]  lad_way,
  input  logic [MASK_W-1:0] lad_mask,
  input  logic [BASE_W-1:0] lad_base,
  input  logic              bnd_we,
  input  logic [TID_W-1:0]  bnd_task,
  input  logic [BP_W-1:0]   bnd_bp,
  output logic [WAY_W-1:0]  way_sel,
  output logic [MASK_W-1:0] set_mask,
  output logic [BASE_W-1:0] set_base,
  output logic              cfg_upd
);

  localparam int ENT_W = WAY_W + MASK_W + BASE_W;

  logic [TID_W-1:0]                run_task;
  logic                            snap_v;
  logic [TID_W-1:0]                snap_task;
  logic [CNT_W-1:0]                snap_acc, snap_miss;
  logic [BP_W-1:0]                 snap_bp;
  logic                            over;
  logic [N_TASKS-1:0][STEP_W-1:0]  step_vec;
  logic [N_TASKS-1:0][ENT_W-1:0]   cur_ent;
  logic [N_TASKS-1:0][WAY_W-1:0]   cur_way;
  logic [WAY_W-1:0]                nxt_way;
  dec_kind_e                       dec_q;
  logic [ENT_W-1:0]                run_ent;

  pr_slice_counter #(.CNT_W(CNT_W), .TID_W(TID_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .acc_stb   (acc_stb),
    .miss_stb  (miss_stb),
    .sw_stb    (sw_stb),
    .sw_task   (sw_task),
    .run_task  (run_task),
    .snap_v    (snap_v),
    .snap_task (snap_task),
    .snap_acc  (snap_acc),
    .snap_miss (snap_miss)
  );

  pr_ladder_store #(
    .N_TASKS(N_TASKS), .N_STEPS(N_STEPS), .WAY_W(WAY_W),
    .ENT_W(ENT_W), .BP_W(BP_W)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .lad_we     (lad_we),
    .lad_task   (lad_task),
    .lad_step   (lad_step),
    .lad_data   ({lad_way, lad_mask, lad_base}),
    .bnd_we     (bnd_we),
    .bnd_task   (bnd_task),
    .bnd_bp     (bnd_bp),
    .step_vec   (step_vec),
    .probe_task (snap_task),
    .cur_ent    (cur_ent),
    .cur_way    (cur_way),
    .nxt_way    (nxt_way),
    .probe_bp   (snap_bp)
  );

  pr_rate_judge #(.CNT_W(CNT_W), .BP_W(BP_W), .THRESH_BP(THRESH_BP)) u_judge (
    .acc     (snap_acc),
    .miss    (snap_miss),
    .base_bp (snap_bp),
    .over    (over)
  );

  pr_step_ctrl #(.N_TASKS(N_TASKS), .N_STEPS(N_STEPS), .WAY_W(WAY_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .eval_v    (snap_v),
    .eval_task (snap_task),
    .over      (over),
    .cur_way   (cur_way),
    .nxt_way   (nxt_way),
    .exit_stb  (exit_stb),
    .exit_task (exit_task),
    .step_vec  (step_vec),
    .dec_q     (dec_q)
  );

  assign run_ent = cur_ent[run_task];

  // registered configuration outputs for the running task
  always_ff @(posedge clk) begin
    if (rst) begin
      way_sel  <= '0;
      set_mask <= '0;
      set_base <= '0;
      cfg_upd  <= 1'b0;
    end else begin
      {way_sel, set_mask, set_base} <= run_ent;
      cfg_upd <= (dec_q != DEC_IDLE);
    end
  end

  AST_UPD_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cfg_upd |-> ($past(sw_stb, 3) || $past(exit_stb, 2))); // R9

endmodule

// File: tb/partition_rescaler_bench.sv
module partition_rescaler_bench;

  localparam int NT = 4, NS = 4, WW = 4, MW = 8, BW = 8, CW = 8, PW = 14, TH = 10;
  localparam int TW = 2, SW = 2;
  localparam int LAST = NS - 1;
  localparam int CMAX = 255;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          acc_stb = 0, miss_stb = 0, sw_stb = 0, exit_stb = 0;
  logic [TW-1:0] sw_task = '0, exit_task = '0, lad_task = '0, bnd_task = '0;
  logic [SW-1:0] lad_step = '0;
  logic          lad_we = 0, bnd_we = 0;
  logic [WW-1:0] lad_way = '0;
  logic [MW-1:0] lad_mask = '0;
  logic [BW-1:0] lad_base = '0;
  logic [PW-1:0] bnd_bp = '0;
  logic [WW-1:0] way_sel;
  logic [MW-1:0] set_mask;
  logic [BW-1:0] set_base;
  logic          cfg_upd;

  partition_rescaler #(
    .N_TASKS(NT), .N_STEPS(NS), .WAY_W(WW), .MASK_W(MW), .BASE_W(BW),
    .CNT_W(CW), .BP_W(PW), .THRESH_BP(TH)
  ) u_partition_rescaler (
    .clk(clk), .rst(rst), .acc_stb(acc_stb), .miss_stb(miss_stb),
    .sw_stb(sw_stb), .sw_task(sw_task), .exit_stb(exit_stb), .exit_task(exit_task),
    .lad_we(lad_we), .lad_task(lad_task), .lad_step(lad_step), .lad_way(lad_way),
    .lad_mask(lad_mask), .lad_base(lad_base), .bnd_we(bnd_we), .bnd_task(bnd_task),
    .bnd_bp(bnd_bp), .way_sel(way_sel), .set_mask(set_mask), .set_base(set_base),
    .cfg_upd(cfg_upd)
  );

  int n_chk = 0, n_fail = 0;
  int step_m[NT];
  int base_m[NT];
  int mask_m[NT][NS];
  int sbase_m[NT][NS];
  int cur_m = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // way vector of task t at step s: s+1 bits from bit t, rotating
  function automatic logic [3:0] way_of(input int t, input int s);
    logic [7:0] run;
    logic [7:0] r;
    run = 8'((1 << (s + 1)) - 1);
    r = run << t;
    return r[3:0] | r[7:4];
  endfunction

  task automatic check_cfg(input string req);
    chk(way_sel == way_of(cur_m, step_m[cur_m]), req, "way_sel",
        longint'(way_sel), longint'(way_of(cur_m, step_m[cur_m])));
    chk(int'(set_mask) == mask_m[cur_m][step_m[cur_m]], req, "set_mask",
        longint'(set_mask), longint'(mask_m[cur_m][step_m[cur_m]]));
    chk(int'(set_base) == sbase_m[cur_m][step_m[cur_m]], req, "set_base",
        longint'(set_base), longint'(sbase_m[cur_m][step_m[cur_m]]));
  endtask

  function automatic void model_grow(input int t);
    int ns[NT];
    logic [3:0] gained;
    gained = way_of(t, step_m[t] + 1) & ~way_of(t, step_m[t]);
    for (int j = 0; j < NT; j++) begin
      ns[j] = step_m[j];
      if (j == t) ns[j]++;
      else if (step_m[j] != LAST && (gained & way_of(j, step_m[j])) != 0) ns[j]++;
    end
    for (int j = 0; j < NT; j++) step_m[j] = ns[j];
  endfunction

  function automatic bit others_busy(input int ex);
    for (int j = 0; j < NT; j++)
      if (j != ex && step_m[j] != 0) return 1'b1;
    return 1'b0;
  endfunction

  // one slice of the running task, then a switch; optional exit in the judging cycle
  task automatic run_slice(input int na, input int nm, input int nxt, input string req,
                           input bit exit_after = 1'b0, input int ex = 0);
    longint ac, mc;
    bit over, exp_pulse;
    for (int i = 0; i < na; i++) begin
      @(negedge clk);
      acc_stb = 1'b1;
      miss_stb = (i < nm);
    end
    @(negedge clk);
    acc_stb = 0; miss_stb = 0;
    sw_stb = 1'b1; sw_task = TW'(nxt);
    ac = (na > CMAX) ? CMAX : na;
    mc = (nm < na) ? nm : na;
    if (mc > CMAX) mc = CMAX;
    over = (mc * 10000) > (ac * longint'(base_m[cur_m] + TH));
    if (exit_after) begin
      exp_pulse = others_busy(ex);
      for (int j = 0; j < NT; j++) step_m[j] = 0;
    end else begin
      exp_pulse = over && (step_m[cur_m] != LAST);
      if (exp_pulse) model_grow(cur_m);
    end
    cur_m = nxt;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 1) begin
        sw_stb = 0;
        if (exit_after) begin exit_stb = 1'b1; exit_task = TW'(ex); end
      end else begin
        exit_stb = 0;
      end
      chk(cfg_upd == (k == 3 && exp_pulse), exit_after ? "R8/R9" : "R9",
          "cfg_upd timing", longint'(cfg_upd), longint'(k == 3 && exp_pulse));
    end
    check_cfg(req);
  endtask

  task automatic do_exit(input int ex);
    bit exp_pulse;
    @(negedge clk);
    exit_stb = 1'b1; exit_task = TW'(ex);
    exp_pulse = others_busy(ex);
    for (int j = 0; j < NT; j++) step_m[j] = 0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      exit_stb = 0;
      chk(cfg_upd == (k == 2 && exp_pulse), "R9", "cfg_upd after exit",
          longint'(cfg_upd), longint'(k == 2 && exp_pulse));
    end
    check_cfg("R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    base_m[0] = 0; base_m[1] = 60; base_m[2] = 150; base_m[3] = 40;
    for (int t = 0; t < NT; t++) step_m[t] = 0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(way_sel == 0 && set_mask == 0 && set_base == 0, "R1", "outputs in reset",
        longint'({way_sel, set_mask, set_base}), 0);
    chk(cfg_upd == 0, "R1", "cfg_upd in reset", longint'(cfg_upd), 0);
    rst = 0;

    // R11: load ladders and baselines
    for (int t = 0; t < NT; t++) begin
      for (int s = 0; s < NS; s++) begin
        @(negedge clk);
        mask_m[t][s] = int'($urandom_range(0, 255));
        sbase_m[t][s] = int'($urandom_range(0, 255));
        lad_we = 1; lad_task = TW'(t); lad_step = SW'(s);
        lad_way = way_of(t, s); lad_mask = MW'(mask_m[t][s]); lad_base = BW'(sbase_m[t][s]);
      end
      @(negedge clk);
      lad_we = 0;
      bnd_we = 1; bnd_task = TW'(t); bnd_bp = PW'(base_m[t]);
    end
    @(negedge clk);
    bnd_we = 0;
    repeat (3) @(negedge clk);
    check_cfg("R10");

    run_slice(0, 0, 1, "R4");            // zero accesses: no rescale
    run_slice(10, 0, 3, "R10");
    run_slice(200, 1, 3, "R4");          // equal to bound (bound 50): no rescale
    run_slice(200, 1, 3, "R2");          // counts cleared, judged alone again
    run_slice(200, 2, 3, "R5");          // over: task3 grows, gains way 0 held by task0
    run_slice(300, 1, 3, "R3");          // 255 accesses saturated: not over
    run_slice(5, 0, 0, "R7");            // task0 forced to grow
    for (int i = 0; i < 4; i++) run_slice(100, 100, 0, "R6");
    do_exit(2);
    run_slice(100, 100, 1, "R5");
    run_slice(100, 100, 1, "R8", 1'b1, 3); // exit in judging cycle wins
    run_slice(50, 50, 2, "R5");
    do_exit(2);                          // only the exiting... others may be idle

    for (int it = 0; it < 60; it++) begin
      int na, nm, nx, pick;
      na = int'($urandom_range(0, 300));
      nm = int'($urandom_range(0, 6));
      nx = int'($urandom_range(0, NT - 1));
      pick = int'($urandom_range(0, 9));
      if (pick == 0) do_exit(int'($urandom_range(0, NT - 1)));
      else if (pick == 1) run_slice(na, nm, nx, "R8", 1'b1, int'($urandom_range(0, NT - 1)));
      else run_slice(na, nm, nx, "R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule